// File: doc/BRIEF.md
# Memory-Mapped Event Counter Pair

This block places two event counters and a shared snapshot register behind a small synchronous bus slave with eight locations. A host selects the slave with three enable conditions and a 3-bit address. Four locations return single bytes of the snapshot. One location captures both live counts into the snapshot. One location clears both counters. The last two locations are spare and do nothing. Capture and clear are side effects of addressing those locations; the block has no dedicated pins for them.

Each counter advances by one on every clock cycle in which its event strobe is high. A mode input picks one of two arrangements. In the independent arrangement each counter follows its own strobe and wraps at its 16-bit limit. In the chained arrangement, the second counter advances only when the first counter wraps. The pair then acts as one 32-bit count of the first strobe, and the second strobe is ignored. The snapshot lets a host read a stable value byte by byte while counting carries on.

Top module: `cnt_periph`

## Requirements
- R1: The slave is selected only in a cycle where `sel_hi` is 1, `sel_n_a` is 0 and `sel_n_b` is 0. In any other cycle no read is answered and no capture or clear happens.
- R2: A selected cycle at a read location gives `rd_valid` = 1 and the byte on `rd_data` one cycle later. Address 0 returns snapshot count A bits 7:0. Address 1 returns A bits 15:8. Address 2 returns count B bits 7:0. Address 3 returns B bits 15:8. While `rd_valid` is 0, `rd_data` is 0.
- R3: Selecting address 4 loads the snapshot with the live counts as they stood before that clock edge. `rd_valid` stays 0. The snapshot keeps its value until the next capture.
- R4: Selecting address 5 sets both counters to zero at that clock edge. `rd_valid` stays 0. A clear overrides any event strobe in the same cycle.
- R5: Addresses 6 and 7 change neither the counters nor the snapshot, and `rd_valid` stays 0.
- R6: A capture or a clear acts once per select assertion, in its first selected cycle, however long the select is held.
- R7: With `mode_chain` = 0, counter A counts `evt_a` cycles and counter B counts `evt_b` cycles, each independently. Each counter wraps from 65535 to 0.
- R8: With `mode_chain` = 1, counter B advances only in a cycle where `evt_a` is high and counter A is at 65535, so {B,A} counts `evt_a` up to 4294967295. `evt_b` has no effect in this mode.
- R9: `a_full` is 1 exactly while counter A holds 65535.
- R10: After synchronous reset, both counters and the snapshot are zero, and `rd_valid` and `a_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| evt_a | input | 1 | Event strobe for counter A, one count per high cycle |
| evt_b | input | 1 | Event strobe for counter B (independent mode only) |
| mode_chain | input | 1 | 0: independent counters; 1: B extends A to 32 bits |
| sel_hi | input | 1 | Select condition, active high |
| sel_n_a | input | 1 | Select condition, active low |
| sel_n_b | input | 1 | Select condition, active low |
| addr | input | 3 | Location within the slave |
| rd_data | output | 8 | Read byte, registered; zero when not valid |
| rd_valid | output | 1 | Read byte valid and bus driven |
| a_full | output | 1 | Counter A is at its top value |

## Verification
The assertions assume that the address is stable for as long as a select is held. They also assume that `mode_chain` changes only between a clear and the next counting. Under these assumptions a carry or a held command always refers to one decoded location. The stimulus drives every input on the falling clock edge. It releases the select for at least one cycle between accesses, and it changes the mode only directly before a clear access. Captures are issued only while both event strobes are low, so the expected snapshot is fixed before it is read back.

// File: rtl/cntmap_pkg.sv
package cntmap_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        LOC_A_LO    = 3'd0,
        LOC_A_HI    = 3'd1,
        LOC_B_LO    = 3'd2,
        LOC_B_HI    = 3'd3,
        LOC_CAPTURE = 3'd4,
        LOC_CLEAR   = 3'd5,
        LOC_SPARE6  = 3'd6,
        LOC_SPARE7  = 3'd7
    } loc_e;

    typedef struct packed {
        logic             rd;
        logic             cap;
        logic             clr;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_loc(loc_e l);
        dec_t d;
        d = '0;
        case (l)
            LOC_A_LO:    begin d.rd = 1'b1; d.idx = 2'd0; end
            LOC_A_HI:    begin d.rd = 1'b1; d.idx = 2'd1; end
            LOC_B_LO:    begin d.rd = 1'b1; d.idx = 2'd2; end
            LOC_B_HI:    begin d.rd = 1'b1; d.idx = 2'd3; end
            LOC_CAPTURE: d.cap = 1'b1;
            LOC_CLEAR:   d.clr = 1'b1;
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_max
);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_max = &cnt;

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc) |=> cnt == $past(cnt) + 1'b1);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import cntmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_hi,
    input  logic              sel_n_a,
    input  logic              sel_n_b,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              cap_pulse,
    output logic              clr_pulse
);

    logic sel_act;
    logic sel_q;
    logic first;
    dec_t dec;

    assign sel_act = sel_hi & ~sel_n_a & ~sel_n_b;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_act;
    end

    assign first     = sel_act & ~sel_q;
    assign dec       = decode_loc(loc_e'(addr));
    assign rd_req    = sel_act & dec.rd;
    assign rd_idx    = dec.idx;
    assign cap_pulse = first & dec.cap;
    assign clr_pulse = first & dec.clr;

    a_r6_cap_once: assert property (@(posedge clk) disable iff (rst)
        cap_pulse |=> !cap_pulse);
    a_r6_clr_once: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !clr_pulse);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sel_hi || sel_n_a || sel_n_b) |-> !(cap_pulse || clr_pulse || rd_req));
    a_r5_spare_quiet: assert property (@(posedge clk) disable iff (rst)
        (addr[2:1] == 2'b11) |-> !(cap_pulse || clr_pulse || rd_req));

endmodule

// File: rtl/snap_reader.sv
module snap_reader
    import cntmap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap,
    input  logic [CNT_W-1:0]   live_a,
    input  logic [CNT_W-1:0]   live_b,
    input  logic               rd_req,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               rd_valid
);

    localparam int SNAP_W = 2 * CNT_W;

    logic [SNAP_W-1:0] snap;
    logic [BYTE_W-1:0] pick;

    always_ff @(posedge clk) begin
        if (rst)      snap <= '0;
        else if (cap) snap <= {live_b, live_a};
    end

    assign pick = snap[int'(rd_idx) * BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? pick : '0;
        end
    end

    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        cap |=> snap == $past({live_b, live_a}));
    a_r3_keep: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(snap));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (!rd_valid && rd_data == '0));

endmodule

// File: rtl/cnt_periph.sv
module cnt_periph
    import cntmap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_a,
    input  logic              evt_b,
    input  logic              mode_chain,
    input  logic              sel_hi,
    input  logic              sel_n_a,
    input  logic              sel_n_b,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              a_full
);

    logic              rd_req;
    logic [IDX_W-1:0]  rd_idx;
    logic              cap_p;
    logic              clr_p;
    logic [CNT_W-1:0]  cnt_a;
    logic [CNT_W-1:0]  cnt_b;
    logic              a_max;
    logic              b_max;
    logic              b_inc;

    cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .sel_hi    (sel_hi),
        .sel_n_a   (sel_n_a),
        .sel_n_b   (sel_n_b),
        .addr      (addr),
        .rd_req    (rd_req),
        .rd_idx    (rd_idx),
        .cap_pulse (cap_p),
        .clr_pulse (clr_p)
    );

    evt_counter #(.W(CNT_W)) u_cnt_a (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_p),
        .inc    (evt_a),
        .cnt    (cnt_a),
        .at_max (a_max)
    );

    assign b_inc = mode_chain ? (evt_a & a_max) : evt_b;

    evt_counter #(.W(CNT_W)) u_cnt_b (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_p),
        .inc    (b_inc),
        .cnt    (cnt_b),
        .at_max (b_max)
    );

    snap_reader #(.CNT_W(CNT_W)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap_p),
        .live_a   (cnt_a),
        .live_b   (cnt_b),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign a_full = a_max;

    a_r8_carry: assert property (@(posedge clk) disable iff (rst)
        (mode_chain && !clr_p && evt_a && a_full) |=> cnt_b == $past(cnt_b) + 1'b1);
    a_r8_b_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode_chain && !clr_p && !(evt_a && a_full)) |=> $stable(cnt_b));
    a_r8_a_wraps: assert property (@(posedge clk) disable iff (rst)
        (!clr_p && evt_a && a_full) |=> cnt_a == '0);

endmodule

// File: tb/test_cnt_periph.sv
module test_cnt_periph;
    import cntmap_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       evt_a, evt_b, mode_chain;
    logic       sel_hi, sel_n_a, sel_n_b;
    logic [2:0] addr;
    logic [7:0] rd_data;
    logic       rd_valid, a_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cnt_periph i_cnt_periph (
        .clk(clk), .rst(rst), .evt_a(evt_a), .evt_b(evt_b),
        .mode_chain(mode_chain), .sel_hi(sel_hi), .sel_n_a(sel_n_a),
        .sel_n_b(sel_n_b), .addr(addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .a_full(a_full)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        sel_hi = 1'b0; sel_n_a = 1'b1; sel_n_b = 1'b1; addr = 3'd0;
    endtask

    // one selected cycle at loc, then one deselected cycle
    task automatic access(logic [2:0] loc, output logic [7:0] d, output logic v);
        @(negedge clk);
        sel_hi = 1'b1; sel_n_a = 1'b0; sel_n_b = 1'b0; addr = loc;
        @(negedge clk);
        d = rd_data; v = rd_valid;
        idle_bus();
    endtask

    task automatic cmd(logic [2:0] loc, string req);
        logic [7:0] d; logic v;
        access(loc, d, v);
        check(req, {31'd0, v}, 0);
        check(req, int'(d), 0);
    endtask

    task automatic read_byte(logic [2:0] loc, int exp, string req);
        logic [7:0] d; logic v;
        access(loc, d, v);
        check(req, {31'd0, v}, 1);
        check(req, int'(d), exp);
    endtask

    task automatic read_snap(int ea, int eb, string req);
        read_byte(3'd0, ea & 8'hFF, req);
        read_byte(3'd1, (ea >> 8) & 8'hFF, req);
        read_byte(3'd2, eb & 8'hFF, req);
        read_byte(3'd3, (eb >> 8) & 8'hFF, req);
    endtask

    task automatic capture_and_read(int ea, int eb, string req);
        cmd(3'd4, "R3");
        read_snap(ea, eb, req);
    endtask

    task automatic count(logic a, logic b, int n);
        @(negedge clk);
        evt_a = a; evt_b = b;
        repeat (n) @(negedge clk);
        evt_a = 1'b0; evt_b = 1'b0;
    endtask

    task automatic t_reset();
        check("R10", {31'd0, rd_valid}, 0);
        check("R10", {31'd0, a_full}, 0);
        read_snap(0, 0, "R10");
        capture_and_read(0, 0, "R10");
    endtask

    task automatic t_dual();
        mode_chain = 1'b0;
        cmd(3'd5, "R4");
        count(1'b1, 1'b0, 5);
        count(1'b0, 1'b1, 3);
        capture_and_read(5, 3, "R7");
        cmd(3'd5, "R4");
        count(1'b1, 1'b1, 65535);
        check("R9", {31'd0, a_full}, 1);
        capture_and_read(16'hFFFF, 16'hFFFF, "R7");
        count(1'b1, 1'b1, 1);
        check("R9", {31'd0, a_full}, 0);
        capture_and_read(0, 0, "R7");
    endtask

    task automatic t_select_gating();
        logic [7:0] d; logic v;
        cmd(3'd5, "R4");
        count(1'b1, 1'b1, 7);
        capture_and_read(7, 7, "R2");
        // clear attempted with each enable wrong in turn
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sel_hi = (k != 0); sel_n_a = (k == 1); sel_n_b = (k == 2);
            addr = 3'd5;
            @(negedge clk);
            idle_bus();
        end
        // read attempted with wrong enable
        @(negedge clk);
        sel_hi = 1'b1; sel_n_a = 1'b1; sel_n_b = 1'b0; addr = 3'd0;
        @(negedge clk);
        d = rd_data; v = rd_valid;
        idle_bus();
        check("R1", {31'd0, v}, 0);
        check("R1", int'(d), 0);
        capture_and_read(7, 7, "R1");
    endtask

    task automatic t_spare();
        count(1'b1, 1'b0, 2);
        cmd(3'd6, "R5");
        cmd(3'd7, "R5");
        read_snap(7, 7, "R5");
        capture_and_read(9, 7, "R5");
    endtask

    task automatic t_held();
        cmd(3'd5, "R4");
        count(1'b1, 1'b0, 10);
        // held capture while counting: snapshot keeps value of first cycle
        @(negedge clk);
        evt_a = 1'b1;
        sel_hi = 1'b1; sel_n_a = 1'b0; sel_n_b = 1'b0; addr = 3'd4;
        repeat (3) @(negedge clk);
        check("R6", {31'd0, rd_valid}, 0);
        idle_bus(); evt_a = 1'b0;
        read_snap(10, 0, "R6");
        // held clear while counting: clear wins once, then counts resume
        @(negedge clk);
        evt_a = 1'b1;
        sel_hi = 1'b1; sel_n_a = 1'b0; sel_n_b = 1'b0; addr = 3'd5;
        repeat (3) @(negedge clk);
        idle_bus(); evt_a = 1'b0;
        capture_and_read(2, 0, "R6");
        capture_and_read(2, 0, "R4");
    endtask

    task automatic t_chain();
        @(negedge clk);
        mode_chain = 1'b1;
        cmd(3'd5, "R4");
        count(1'b1, 1'b1, 65535);
        check("R9", {31'd0, a_full}, 1);
        capture_and_read(16'hFFFF, 0, "R8");
        count(1'b1, 1'b0, 1);
        check("R9", {31'd0, a_full}, 0);
        capture_and_read(0, 1, "R8");
        count(1'b0, 1'b1, 4);
        count(1'b1, 1'b0, 3);
        capture_and_read(3, 1, "R8");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt_a = 1'b0; evt_b = 1'b0; mode_chain = 1'b0;
        idle_bus();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dual();
        t_select_gating();
        t_spare();
        t_held();
        t_chain();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule